// File: doc/BRIEF.md
# Selectable PRBS Generator and Checker

This block is a pseudo-random bit sequence test engine for a serial link datapath. Its transmit side emits one pattern bit per clock. Its receive side takes one bit per clock, locks onto the incoming stream and counts bit errors. Each side has its own enable bit and its own pattern-select field. The select code picks either a 2^7-1 sequence, built on x^7+x^6+1, or a 2^23-1 sequence, built on x^23+x^18+1. The two remaining codes switch pattern activity off.

Software drives the block through a small register port. It writes the two configuration registers and then restarts the pattern logic with a datapath reset pulse: it writes the reset bit to 1 and then back to 0. A select change reaches the pattern logic only through that pulse. A read of the error count returns the count and clears it. The usual flow is to read once and discard the value, then read again later; a result of zero means the link was clean over that interval. A live error flag marks each detected mismatch as it happens.

Top module: `prbs_test_engine`

## Requirements
- R1: After the synchronous reset, `tx_bit` and `err_live` are 0, and every register reads 0.
- R2: With generator code 2'b10 and the generator enabled, the first bits after a datapath reset pulse follow b[n] = b[n-7] XOR b[n-6], with every bit before b[0] taken as 1 (seed of all ones).
- R3: With generator code 2'b11 and the generator enabled, the first bits after a datapath reset pulse follow b[n] = b[n-23] XOR b[n-18], with every bit before b[0] taken as 1.
- R4: While the generator enable (bit 2 of address 0) is 0, `tx_bit` is 0.
- R5: Codes 2'b00 and 2'b01 turn pattern activity off. The generator outputs 0, and the checker neither counts nor raises the flag.
- R6: The checker (bits 1:0 select, bit 2 enable, at address 1) shifts received bits into its own register and starts checking once it has shifted order+1 bits. It flags each received bit that differs from the feedback prediction. A clean stream gives no errors. One isolated flipped bit gives exactly 3 errors: at the bit itself and at the two later bits whose prediction taps it.
- R7: `err_live` is high for exactly one cycle per detected mismatch, in the cycle after the bit is sampled.
- R8: A read of address 3 returns the 8-bit count and clears it at that clock edge. If a new error arrives in the same cycle as the clearing read, the count becomes 1.
- R9: The count saturates at 255 rather than wrapping.
- R10: A new select code takes effect only after a datapath reset pulse on bit 0 of address 2. Until then the sequence already running continues.
- R11: While the checker enable is 0, errors are neither counted nor flagged.
- R12: Addresses 0 to 2 read back the byte last written. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the count at address 3) |
| reg_addr | input | 2 | Register address: 0 generator, 1 checker, 2 datapath reset, 3 error count |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tx_bit | output | 1 | Generated pattern bit |
| rx_bit | input | 1 | Received bit |
| err_live | output | 1 | Live mismatch flag |

## Verification
The assertions assume that software asserts the datapath reset bit before it relies on a new select code. They also assume that read and write strobes occur only for one address per cycle. The bench keeps within both assumptions: it restarts through the 1-then-0 pulse after each intended mode change and drives at most one strobe at a time. Flipped receive bits are spaced wider than the longest tap distance, so the bench can predict errors as exactly three per flip, counting both taps. Random runs choose the mode, the number of flips and the gaps from a fixed seed.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
    typedef enum logic [1:0] {
        PAT_NONE0 = 2'b00,
        PAT_NONE1 = 2'b01,
        PAT_SHORT = 2'b10,
        PAT_LONG  = 2'b11
    } pat_sel_e;

    localparam int LFSR_W    = 23;
    localparam int SHORT_ORD = 7;
    localparam int LONG_ORD  = 23;
    localparam int FILL_W    = 5;

    localparam logic [1:0] ADDR_GEN = 2'd0;
    localparam logic [1:0] ADDR_CHK = 2'd1;
    localparam logic [1:0] ADDR_DPR = 2'd2;
    localparam logic [1:0] ADDR_CNT = 2'd3;

    // feedback of x^7+x^6+1 or x^23+x^18+1 over a left-shifting register
    function automatic logic fb_bit(input logic [LFSR_W-1:0] s, input logic long_mode);
        fb_bit = long_mode ? (s[LONG_ORD-1] ^ s[17]) : (s[SHORT_ORD-1] ^ s[5]);
    endfunction

    function automatic logic pat_active(input logic [1:0] sel);
        pat_active = sel[1];
    endfunction
endpackage

// File: rtl/prbs_regs.sv
module prbs_regs
    import prbs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  err_count,
    output logic              cnt_clr,
    output logic [1:0]        gen_sel,
    output logic              gen_en,
    output logic [1:0]        chk_sel,
    output logic              chk_en,
    output logic              dp_rst
);
    typedef struct packed {
        logic [DATA_W-1:0] gen_cfg;
        logic [DATA_W-1:0] chk_cfg;
        logic [DATA_W-1:0] dpr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_GEN: r_d.gen_cfg = reg_wdata;
                ADDR_CHK: r_d.chk_cfg = reg_wdata;
                ADDR_DPR: r_d.dpr     = reg_wdata;
                default:  r_d         = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        case (reg_addr)
            ADDR_GEN: reg_rdata = r_q.gen_cfg;
            ADDR_CHK: reg_rdata = r_q.chk_cfg;
            ADDR_DPR: reg_rdata = r_q.dpr;
            default:  reg_rdata = DATA_W'(err_count);
        endcase
    end

    assign cnt_clr = reg_rd && (reg_addr == ADDR_CNT);
    assign gen_sel = r_q.gen_cfg[1:0];
    assign gen_en  = r_q.gen_cfg[2];
    assign chk_sel = r_q.chk_cfg[1:0];
    assign chk_en  = r_q.chk_cfg[2];
    assign dp_rst  = r_q.dpr[0];

    // R12
    cnt_addr_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_CNT) |=> $stable(r_q));
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
    import prbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dp_rst,
    input  logic [1:0] sel_cfg,
    input  logic       en,
    output logic       tx_bit
);
    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [1:0]        sel;
        logic              tx;
    } gen_t;

    gen_t g_d, g_q;
    logic nb;

    always_comb begin
        g_d = g_q;
        nb  = fb_bit(g_q.lfsr, g_q.sel[0]);
        if (dp_rst) begin
            g_d.lfsr = '1;
            g_d.sel  = sel_cfg;
            g_d.tx   = 1'b0;
        end else if (en && pat_active(g_q.sel)) begin
            g_d.lfsr = {g_q.lfsr[LFSR_W-2:0], nb};
            g_d.tx   = nb;
        end else begin
            g_d.tx   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_q.lfsr <= '1;
            g_q.sel  <= PAT_NONE0;
            g_q.tx   <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

    assign tx_bit = g_q.tx;

    // R2
    short_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (g_q.sel == PAT_SHORT) |-> (g_q.lfsr[SHORT_ORD-1:0] != '0));
    // R3
    long_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (g_q.sel == PAT_LONG) |-> (g_q.lfsr != '0));
    // R4
    gen_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tx_bit);
    // R5
    gen_code_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!pat_active(g_q.sel) && !dp_rst) |=> !tx_bit);
    // R10
    gen_sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dp_rst |=> $stable(g_q.sel));
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
    import prbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dp_rst,
    input  logic [1:0] sel_cfg,
    input  logic       en,
    input  logic       rx_bit,
    output logic       hit,
    output logic       err_live
);
    typedef struct packed {
        logic [LFSR_W-1:0] shr;
        logic [1:0]        sel;
        logic [FILL_W-1:0] fill;
        logic              err;
    } chk_t;

    chk_t c_d, c_q;
    logic pred;
    logic filled;
    logic [FILL_W-1:0] need;

    always_comb begin
        c_d    = c_q;
        hit    = 1'b0;
        pred   = fb_bit(c_q.shr, c_q.sel[0]);
        need   = c_q.sel[0] ? FILL_W'(LONG_ORD + 1) : FILL_W'(SHORT_ORD + 1);
        filled = (c_q.fill >= need);
        if (dp_rst) begin
            c_d.shr  = '0;
            c_d.sel  = sel_cfg;
            c_d.fill = '0;
            c_d.err  = 1'b0;
        end else if (en && pat_active(c_q.sel)) begin
            hit      = filled && (rx_bit != pred);
            c_d.err  = hit;
            c_d.shr  = {c_q.shr[LFSR_W-2:0], rx_bit};
            if (c_q.fill != '1) c_d.fill = c_q.fill + 1'b1;
        end else begin
            c_d.fill = '0;
            c_d.err  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.shr  <= '0;
            c_q.sel  <= PAT_NONE0;
            c_q.fill <= '0;
            c_q.err  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign err_live = c_q.err;

    // R11
    chk_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !err_live);
    // R5
    chk_code_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pat_active(c_q.sel) |=> !err_live);
    // R10
    chk_restart_chk: assert property (@(posedge clk) disable iff (rst)
        dp_rst |=> (!err_live && c_q.fill == '0));
    // R7
    flag_follows_hit_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> err_live);
endmodule

// File: rtl/prbs_errcnt.sv
module prbs_errcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t n_d, n_q;
    logic [CNT_W-1:0] base;

    always_comb begin
        base = clr ? '0 : n_q.cnt;
        n_d.cnt = base;
        if (hit && base != CNT_MAX) n_d.cnt = base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) n_q <= '0;
        else     n_q <= n_d;
    end

    assign count = n_q.cnt;

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX && !clr) |=> (count == CNT_MAX));
    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> (count == '0));
    // R8
    clear_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && hit) |=> (count == CNT_W'(1)));
    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !hit) |=> $stable(count));
endmodule

// File: rtl/prbs_test_engine.sv
module prbs_test_engine
    import prbs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_bit,
    input  logic              rx_bit,
    output logic              err_live
);
    logic [CNT_W-1:0] err_count;
    logic       cnt_clr, hit, dp_rst;
    logic [1:0] gen_sel, chk_sel;
    logic       gen_en, chk_en;

    prbs_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_count(err_count), .cnt_clr(cnt_clr),
        .gen_sel(gen_sel), .gen_en(gen_en),
        .chk_sel(chk_sel), .chk_en(chk_en), .dp_rst(dp_rst)
    );

    prbs_gen u_gen (
        .clk(clk), .rst(rst), .dp_rst(dp_rst),
        .sel_cfg(gen_sel), .en(gen_en), .tx_bit(tx_bit)
    );

    prbs_chk u_chk (
        .clk(clk), .rst(rst), .dp_rst(dp_rst),
        .sel_cfg(chk_sel), .en(chk_en), .rx_bit(rx_bit),
        .hit(hit), .err_live(err_live)
    );

    prbs_errcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .hit(hit), .clr(cnt_clr), .count(err_count)
    );
endmodule

// File: tb/prbs_test_engine_test.sv
`timescale 1ns/1ps
module prbs_test_engine_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tx_bit, err_live, rx_bit;
    logic       flip = 1'b0;
    int         checks = 0, errors = 0, live_n = 0;
    bit         cap [0:63];
    logic [7:0] v;

    assign rx_bit = tx_bit ^ flip;
    always #2 clk = ~clk;

    prbs_test_engine uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .err_live(err_live)
    );

    always @(negedge clk) if (err_live === 1'b1) live_n++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int idx, input bit lng);
        bit h [0:99];
        int o = lng ? 23 : 7;
        int t = lng ? 18 : 6;
        for (int i = 0; i < 100; i++) h[i] = 1'b1;
        for (int n = 0; n <= idx; n++) h[n + 30] = h[n + 30 - o] ^ h[n + 30 - t];
        return h[idx + 30];
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #0.5 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse();
        wr(2'd2, 8'h01);
        wr(2'd2, 8'h00);
    endtask

    task automatic collect(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cap[i] = tx_bit;
        end
    endtask

    task automatic inject(input int flips, input int gap);
        for (int f = 0; f < flips; f++) begin
            @(negedge clk); flip = 1'b1;
            @(negedge clk); flip = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic seq_check(input string req, input int n, input bit lng);
        int bad = 0;
        for (int i = 0; i < n; i++) if (cap[i] != exp_bit(i, lng)) bad++;
        check(req, bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bad;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        check("R1 tx", tx_bit, 0);
        check("R1 flag", err_live, 0);
        rd(2'd0, v); check("R1 gen reg", v, 0);
        rd(2'd3, v); check("R1 count", v, 0);
        // R12 readback and read-only count
        wr(2'd1, 8'hA6); rd(2'd1, v); check("R12 chk readback", v, 8'hA6);
        wr(2'd3, 8'h55); rd(2'd3, v); check("R12 count ro", v, 0);

        // R2 short sequence
        wr(2'd0, 8'h06); wr(2'd1, 8'h06); pulse();
        collect(40); seq_check("R2 short seq", 40, 1'b0);
        rd(2'd3, v); repeat (20) @(negedge clk);
        rd(2'd3, v); check("R6 clean short", v, 0);
        // R6/R7 single flip
        live_n = 0; inject(1, 15);
        rd(2'd3, v); check("R6 one flip", v, 3);
        check("R7 flag pulses", live_n, 3);
        // R8 clear coinciding with new error
        repeat (10) @(negedge clk);
        rd(2'd3, v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd3; flip = 1'b1;
        #0.5 v = reg_rdata; check("R8 pre value", v, 0);
        @(negedge clk); reg_rd = 1'b0; flip = 1'b0;
        rd(2'd3, v); check("R8 clear plus hit", v, 1);
        repeat (12) @(negedge clk); rd(2'd3, v);
        // R9 saturation
        inject(90, 9);
        rd(2'd3, v); check("R9 saturate", v, 255);
        rd(2'd3, v); check("R8 cleared", v, 0);

        // R10 select change waits for pulse
        wr(2'd0, 8'h07);
        collect(40);
        bad = 0;
        for (int n = 7; n < 40; n++) if (cap[n] != (cap[n-7] ^ cap[n-6])) bad++;
        check("R10 short continues", bad, 0);
        rd(2'd3, v); check("R10 no errors", v, 0);
        // R3 long sequence after pulse
        wr(2'd1, 8'h07); pulse();
        collect(40); seq_check("R3 long seq", 40, 1'b1);
        rd(2'd3, v); live_n = 0; inject(1, 30);
        rd(2'd3, v); check("R6 long flip", v, 3);
        check("R7 long pulses", live_n, 3);

        // R4 generator disabled
        wr(2'd0, 8'h03); collect(20);
        bad = 0; for (int i = 0; i < 20; i++) bad += cap[i];
        check("R4 tx idle", bad, 0);
        // R11 checker disabled
        wr(2'd1, 8'h03); rd(2'd3, v); live_n = 0;
        inject(4, 30);
        rd(2'd3, v); check("R11 no count", v, 0);
        check("R11 no flag", live_n, 0);
        // R5 off codes
        wr(2'd0, 8'h04); wr(2'd1, 8'h05); pulse();
        collect(30);
        bad = 0; for (int i = 0; i < 30; i++) bad += cap[i];
        check("R5 tx off", bad, 0);
        live_n = 0; inject(4, 30);
        rd(2'd3, v); check("R5 no count", v, 0);
        check("R5 no flag", live_n, 0);

        // random runs
        for (int it = 0; it < 8; it++) begin
            bit lng = 1'($urandom_range(0, 1));
            int nf  = $urandom_range(1, 6);
            int gap = $urandom_range(26, 60);
            wr(2'd0, lng ? 8'h07 : 8'h06);
            wr(2'd1, lng ? 8'h07 : 8'h06);
            pulse();
            collect(32); seq_check(lng ? "R3 random seq" : "R2 random seq", 32, lng);
            rd(2'd3, v); live_n = 0;
            inject(nf, gap);
            rd(2'd3, v); check("R6 random count", v, 3 * nf);
            check("R7 random flag", live_n, 3 * nf);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule